// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a stereo serial audio stream made of three wires: a bit clock, a data line and a word clock. It turns the stream into parallel two's-complement samples in the system clock domain. All three wires are brought into the system clock domain through multi-flop synchronisers. Data is shifted into a register on each rising edge of the bit clock. Each transition of the word clock closes a word: the newest bits received before that transition form the sample. Because the sample is taken from the newest bits, the format is right-justified, and any extra leading bit clocks in a slot have no effect.

A mode input selects a word length of 18 or 16 bits. A 16-bit sample is placed in the upper bits of the 18-bit output, and its two lowest bits are zero. The word clock level that held while a word was being sent names its channel: high is channel one, low is channel two. Each channel has its own output register. A one-cycle valid pulse and a channel tag mark every captured word.

An active-low initialisation input, sampled in the system clock domain, holds the receiver idle. A synchronous reset also holds it idle. After either one is released, the first word clock transition only marks the start of a frame and produces no sample.

Top module: `serial_audio_rx`

## Requirements
- R1: In the cycle after synchronous reset is released, both sample outputs are zero, the channel tag is 0 and the valid output is low.
- R2: Data is sampled on bit-clock rising edges, MSB first, in two's complement. A word-clock transition captures the newest 18 bits (mode high) or the newest 16 bits (mode low) received before it.
- R3: A word captured at a falling word-clock edge is loaded into the channel-one output with tag 1. A word captured at a rising edge is loaded into the channel-two output with tag 0. The output register of the other channel does not change.
- R4: When the mode input is low, the 16 received bits appear in output bits [17:2] and output bits [1:0] are 0. When it is high, all 18 bits appear unchanged.
- R5: Bit-clock cycles in a word slot beyond the selected word length, sent before the word, have no effect on the captured sample.
- R6: Exactly one valid pulse, one cycle long, is issued per captured word. The sample outputs and the tag change only in the cycle in which valid is high.
- R7: While the initialisation input is low, no valid pulse is issued and the sample outputs keep their values.
- R8: After reset or initialisation is released, the first word-clock transition produces no valid pulse. Every later transition produces one.
- R9: Valid rises no more than 4 system clock cycles after the word-clock input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Active-low initialisation, synchronous to clk |
| bclk_in | input | 1 | Serial bit clock |
| sdata_in | input | 1 | Serial data, MSB first |
| wclk_in | input | 1 | Word clock, high marks channel one |
| len18 | input | 1 | Word length select: 1 = 18 bits, 0 = 16 bits |
| ch1_word | output | 18 | Last channel-one sample |
| ch2_word | output | 18 | Last channel-two sample |
| word_is_ch1 | output | 1 | Channel tag of the latest sample |
| word_valid | output | 1 | One-cycle pulse per captured sample |

## Verification
A shift register that is out of step, or a bit-clock edge detector that misses or repeats an edge, shows up as a shifted or corrupted value on the next valid pulse. That pulse comes no more than four cycles after the word clock changes. A wrong arming state shows up in one of two ways: a sample appears at the first transition after release, or no sample appears at the second. Logic that steers a word to the wrong channel shows up as the other channel's register changing, or as a wrong tag, in the same cycle as valid. The bench checks each captured value against a word it builds itself from the serial pattern it drives.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int unsigned LONG_W  = 18;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned SYNC_N  = 2;

  typedef enum logic {
    CH_TWO = 1'b0,
    CH_ONE = 1'b1
  } chan_e;
endpackage

// File: rtl/sarx_sync.sv
// Multi-flop synchroniser for a group of slow asynchronous inputs.
// The flops are not reset, so they track the pins while reset is held.
module sarx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) stg <= d;
    end else begin : g_many
      always_ff @(posedge clk) stg <= {stg[STAGES-2:0], d};
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sarx_shifter.sv
// Detects bit-clock rising edges and shifts serial data in, MSB first.
module sarx_shifter #(
  parameter int unsigned DEPTH = 18
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             bclk_s,
  input  logic             data_s,
  output logic [DEPTH-1:0] bits
);
  logic bclk_d;
  logic rise;

  assign rise = bclk_s & ~bclk_d;

  always_ff @(posedge clk) bclk_d <= bclk_s;

  always_ff @(posedge clk) begin
    if (clear)     bits <= '0;
    else if (rise) bits <= {bits[DEPTH-2:0], data_s};
  end
endmodule

// File: rtl/sarx_framer.sv
// Finds word-clock transitions. The first transition after idle only arms
// the framer; each later transition requests a capture for the channel
// named by the level that held before it.
module sarx_framer
  import sarx_pkg::*;
(
  input  logic  clk,
  input  logic  idle,
  input  logic  wclk_s,
  output logic  take,
  output chan_e chan
);
  logic wclk_d;
  logic armed;
  logic flip;

  assign flip = wclk_s ^ wclk_d;

  always_ff @(posedge clk) wclk_d <= wclk_s;

  always_ff @(posedge clk) begin
    if (idle)      armed <= 1'b0;
    else if (flip) armed <= 1'b1;
  end

  assign take = flip & armed & ~idle;
  assign chan = chan_e'(wclk_d);
endmodule

// File: rtl/sarx_capture.sv
// Aligns the selected word length and loads the per-channel output registers.
module sarx_capture
  import sarx_pkg::*;
#(
  parameter int unsigned OUT_W   = 18,
  parameter int unsigned SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  chan_e            chan,
  input  logic             len18,
  input  logic [OUT_W-1:0] bits,
  output logic [OUT_W-1:0] ch1_word,
  output logic [OUT_W-1:0] ch2_word,
  output logic             word_is_ch1,
  output logic             word_valid
);
  localparam int unsigned PAD = OUT_W - SHORT_W;

  logic [OUT_W-1:0] short_al;
  logic [OUT_W-1:0] word;

  generate
    if (PAD == 0) begin : g_nopad
      assign short_al = bits;
    end else begin : g_pad
      assign short_al = {bits[SHORT_W-1:0], {PAD{1'b0}}};
    end
  endgenerate

  assign word = len18 ? bits : short_al;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1_word    <= '0;
      ch2_word    <= '0;
      word_is_ch1 <= 1'b0;
      word_valid  <= 1'b0;
    end else begin
      word_valid <= take;
      if (take) begin
        word_is_ch1 <= (chan == CH_ONE);
        if (chan == CH_ONE) ch1_word <= word;
        else                ch2_word <= word;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned OUT_W   = LONG_W,
  parameter int unsigned SHORT_W = sarx_pkg::SHORT_W,
  parameter int unsigned SYNC_N  = sarx_pkg::SYNC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_n,
  input  logic             bclk_in,
  input  logic             sdata_in,
  input  logic             wclk_in,
  input  logic             len18,
  output logic [OUT_W-1:0] ch1_word,
  output logic [OUT_W-1:0] ch2_word,
  output logic             word_is_ch1,
  output logic             word_valid
);
  logic [2:0]       pins_s;
  logic             idle;
  logic [OUT_W-1:0] bits;
  logic             take;
  chan_e            chan;

  assign idle = rst | ~init_n;

  sarx_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .d   ({bclk_in, sdata_in, wclk_in}),
    .q   (pins_s)
  );

  sarx_shifter #(.DEPTH(OUT_W)) u_shift (
    .clk    (clk),
    .clear  (idle),
    .bclk_s (pins_s[2]),
    .data_s (pins_s[1]),
    .bits   (bits)
  );

  sarx_framer u_frame (
    .clk    (clk),
    .idle   (idle),
    .wclk_s (pins_s[0]),
    .take   (take),
    .chan   (chan)
  );

  sarx_capture #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .chan        (chan),
    .len18       (len18),
    .bits        (bits),
    .ch1_word    (ch1_word),
    .ch2_word    (ch2_word),
    .word_is_ch1 (word_is_ch1),
    .word_valid  (word_valid)
  );
endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int unsigned OUT_W   = 18,
  parameter int unsigned SHORT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             init_n,
  input logic             len18,
  input logic [OUT_W-1:0] ch1_word,
  input logic [OUT_W-1:0] ch2_word,
  input logic             word_is_ch1,
  input logic             word_valid
);
  localparam int unsigned PAD = OUT_W - SHORT_W;
  localparam logic [OUT_W-1:0] PAD_MASK = OUT_W'((1 << PAD) - 1);

  logic [OUT_W-1:0] sel_word;
  assign sel_word = word_is_ch1 ? ch1_word : ch2_word;

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch1_word == '0 && ch2_word == '0 && !word_is_ch1 && !word_valid));

  // R3
  ch1_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_is_ch1) |-> $stable(ch2_word));

  // R3
  ch2_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_is_ch1) |-> $stable(ch1_word));

  // R4
  short_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !$past(len18)) |-> ((sel_word & PAD_MASK) == '0));

  // R6
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> ($stable(ch1_word) && $stable(ch2_word) && $stable(word_is_ch1)));

  // R7
  init_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(init_n) |-> !word_valid);
endmodule

bind serial_audio_rx sarx_checker #(.OUT_W(OUT_W), .SHORT_W(SHORT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .init_n      (init_n),
  .len18       (len18),
  .ch1_word    (ch1_word),
  .ch2_word    (ch2_word),
  .word_is_ch1 (word_is_ch1),
  .word_valid  (word_valid)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst, init_n, bclk_in, sdata_in, wclk_in, len18;
  logic [17:0] ch1_word, ch2_word;
  logic        word_is_ch1, word_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [17:0] log_val [64];
  logic        log_ch  [64];
  int          log_cyc [64];
  int          log_n  = 0;
  int          dbl    = 0;
  logic        prev_v = 1'b0;
  int          t_flip = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx uut (
    .clk(clk), .rst(rst), .init_n(init_n), .bclk_in(bclk_in),
    .sdata_in(sdata_in), .wclk_in(wclk_in), .len18(len18),
    .ch1_word(ch1_word), .ch2_word(ch2_word),
    .word_is_ch1(word_is_ch1), .word_valid(word_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid && prev_v) dbl = dbl + 1;
      if (word_valid && log_n < 64) begin
        log_val[log_n] = word_is_ch1 ? ch1_word : ch2_word;
        log_ch[log_n]  = word_is_ch1;
        log_cyc[log_n] = cyc;
        log_n = log_n + 1;
      end
    end
    prev_v = word_valid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_word(input logic [17:0] val, input int nbits, input int lead);
    for (int i = 0; i < lead; i++) begin
      sdata_in = 1'b1; bclk_in = 1'b0; wait_clk(4);
      bclk_in = 1'b1; wait_clk(4);
    end
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata_in = val[i]; bclk_in = 1'b0; wait_clk(4);
      bclk_in = 1'b1; wait_clk(4);
    end
    bclk_in = 1'b0; wait_clk(4);
  endtask

  task automatic close_word();
    t_flip  = cyc;
    wclk_in = ~wclk_in;
    wait_clk(8);
  endtask

  task automatic t_reset();
    check(ch1_word == 0, "R1 ch1 after reset", 32'(ch1_word), 0);
    check(ch2_word == 0, "R1 ch2 after reset", 32'(ch2_word), 0);
    check(!word_valid && !word_is_ch1, "R1 valid/tag after reset",
          {30'd0, word_valid, word_is_ch1}, 0);
  endtask

  task automatic t_first_edge();
    close_word();
    send_word(18'h2A5A5, 18, 0);
    check(log_n == 0, "R8 first edge after reset gives no sample", log_n, 0);
  endtask

  task automatic t_long_words();
    close_word();
    check(log_n == 1, "R6 one valid for first word", log_n, 1);
    check(log_val[0] == 18'h2A5A5, "R2 ch1 18-bit value", 32'(log_val[0]), 32'h2A5A5);
    check(log_ch[0] == 1'b1, "R3 tag for high-slot word", 32'(log_ch[0]), 1);
    check(log_cyc[0] - t_flip <= 4, "R9 latency", log_cyc[0] - t_flip, 4);
    send_word(18'h3FFFE, 18, 0);
    close_word();
    check(log_val[1] == 18'h3FFFE && log_ch[1] == 1'b0, "R3 ch2 negative word",
          {13'd0, log_ch[1], log_val[1]}, {13'd0, 1'b0, 18'h3FFFE});
    check(ch1_word == 18'h2A5A5, "R3 ch1 kept on ch2 capture", 32'(ch1_word), 32'h2A5A5);
    check(ch2_word == 18'h3FFFE, "R2 ch2 port value", 32'(ch2_word), 32'h3FFFE);
  endtask

  task automatic t_lead_bits();
    send_word(18'h00003, 18, 5);
    close_word();
    check(log_val[2] == 18'h00003 && log_ch[2], "R5 leading bits ignored",
          32'(log_val[2]), 32'h3);
  endtask

  task automatic t_short();
    len18 = 1'b0;
    send_word(18'h08001, 16, 2);
    close_word();
    check(log_val[3] == 18'h20004 && !log_ch[3], "R4 16-bit left aligned ch2",
          32'(log_val[3]), 32'h20004);
    send_word(18'h07FF0, 16, 0);
    close_word();
    check(log_val[4] == 18'h1FFC0 && log_ch[4], "R4 16-bit zero lsbs ch1",
          32'(log_val[4]), 32'h1FFC0);
    check(ch2_word == 18'h20004, "R3 ch2 kept on ch1 capture", 32'(ch2_word), 32'h20004);
    len18 = 1'b1;
  endtask

  task automatic t_init();
    init_n = 1'b0;
    send_word(18'h12345, 18, 0);
    close_word();
    send_word(18'h0ABCD, 18, 0);
    close_word();
    check(log_n == 5, "R7 no valid while init low", log_n, 5);
    check(ch1_word == 18'h1FFC0, "R7 ch1 held during init", 32'(ch1_word), 32'h1FFC0);
    init_n = 1'b1;
    send_word(18'h0000F, 4, 0);
    close_word();
    check(log_n == 5, "R8 first edge after init gives no sample", log_n, 5);
    send_word(18'h15555, 18, 0);
    close_word();
    check(log_n == 6 && log_val[5] == 18'h15555 && log_ch[5], "R8 second edge captures",
          32'(log_val[5]), 32'h15555);
  endtask

  initial begin
    rst = 1'b1; init_n = 1'b1; bclk_in = 1'b0; sdata_in = 1'b0;
    wclk_in = 1'b0; len18 = 1'b1;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_first_edge();
    t_long_words();
    t_lead_bits();
    t_short();
    t_init();
    check(dbl == 0, "R6 valid pulses one cycle wide", dbl, 0);
    check(log_n == 6, "R6 valid count equals words", log_n, 6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule